// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors and a chooser. The first component is a plain table of 2-bit saturating counters, indexed by branch address bits. The second component is a correlating table. Each address row of that table holds four 2-bit counters, and the current 2-bit global outcome history picks one of them. A third table of 2-bit chooser counters, also indexed by address, decides which component's prediction goes out.

The prediction port is combinational. It takes a branch address and returns the direction and which component supplied it. The answer is based on the tables and history as they stand in that cycle.

The update port carries a resolved branch address and its real outcome. On each update the block does four things at the clock edge:
- It re-reads both component predictions for that address, using the current history.
- It trains both components toward the outcome.
- It moves the chooser only when exactly one component was right.
- It shifts the outcome into the history.

Index widths are parameters. The defaults keep each table at 1024 counters.

Top module: `tourney_bpred`

## Requirements
- R1: After reset every counter in all three tables holds 01 and the history holds 00. Any address is then predicted not-taken (pred_taken=0) from the plain component (pred_use_corr=0).
- R2: A component counter predicts taken when its upper bit is 1 (states 10 and 11) and not-taken for states 00 and 01.
- R3: Chooser states 10 and 11 select the correlating component (pred_use_corr=1). States 00 and 01 select the plain component (pred_use_corr=0). pred_taken is the selected component's prediction.
- R4: On an update the chooser entry steps one state toward the correlating side when only the correlating component was right. It steps toward the plain side when only the plain component was right. It does not change when both or neither were right. It saturates at 00 and 11.
- R5: Both component counters addressed by an update step one state toward the outcome (up for taken, down for not-taken), whichever component was chosen. They saturate at 00 and 11.
- R6: The history is a 2-bit shift register: each update shifts the outcome in at bit 0. The correlating counter used is the one at column {history} in the row given by the address.
- R7: The plain table and the chooser use address bits [PC_LSB+IDX-1:PC_LSB]. The correlating row uses bits [PC_LSB+CR_IDX-1:PC_LSB]. Addresses that differ only outside these bits share entries.
- R8: While upd_valid is low, no table entry and no history bit changes, whatever upd_pc and upd_taken carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_use_corr | output | 1 | 1 when the correlating component supplied the prediction |
| upd_valid | input | 1 | An outcome is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench trains one address with an alternating pattern. There the plain counters keep guessing wrong while the history-indexed counters learn, so the chooser must cross to the correlating side. A design that moved the chooser on any misprediction, or that trained only the chosen component, would flip back and forth or never cross. Long runs of one outcome push every counter into both saturation ends, which would expose counters that wrap. Idle cycles with changing update data, and probes of aliased addresses, catch writes that leak past upd_valid and index bits taken from the wrong part of the address. A wrong history shift order would send the learned pattern to the wrong correlating column and flip the predicted direction.

// File: rtl/tourney_bpred.sv
module tourney_bpred #(
  parameter int PC_W    = 32,
  parameter int PC_LSB  = 2,
  parameter int NC_IDX  = 10,
  parameter int CR_IDX  = 8,
  parameter int SEL_IDX = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_use_corr,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int NC_N  = 1 << NC_IDX;
  localparam int CR_W  = CR_IDX + 2;
  localparam int CR_N  = 1 << CR_W;
  localparam int SEL_N = 1 << SEL_IDX;

  logic [NC_N-1:0][1:0]  nc_q;
  logic [CR_N-1:0][1:0]  cr_q;
  logic [SEL_N-1:0][1:0] sel_q;
  logic [1:0]            ghist;

  function automatic logic [1:0] step2(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  wire [NC_IDX-1:0]  p_nc  = pred_pc[PC_LSB+NC_IDX-1:PC_LSB];
  wire [CR_W-1:0]    p_cr  = {pred_pc[PC_LSB+CR_IDX-1:PC_LSB], ghist};
  wire [SEL_IDX-1:0] p_sel = pred_pc[PC_LSB+SEL_IDX-1:PC_LSB];

  assign pred_use_corr = sel_q[p_sel][1];
  assign pred_taken    = pred_use_corr ? cr_q[p_cr][1] : nc_q[p_nc][1];

  wire [NC_IDX-1:0]  u_nc  = upd_pc[PC_LSB+NC_IDX-1:PC_LSB];
  wire [CR_W-1:0]    u_cr  = {upd_pc[PC_LSB+CR_IDX-1:PC_LSB], ghist};
  wire [SEL_IDX-1:0] u_sel = upd_pc[PC_LSB+SEL_IDX-1:PC_LSB];

  wire nc_ok = nc_q[u_nc][1] == upd_taken;
  wire cr_ok = cr_q[u_cr][1] == upd_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nc_q  <= {NC_N{2'b01}};
      cr_q  <= {CR_N{2'b01}};
      sel_q <= {SEL_N{2'b01}};
      ghist <= 2'b00;
    end else if (upd_valid) begin
      nc_q[u_nc] <= step2(nc_q[u_nc], upd_taken);
      cr_q[u_cr] <= step2(cr_q[u_cr], upd_taken);
      if (nc_ok != cr_ok) sel_q[u_sel] <= step2(sel_q[u_sel], cr_ok);
      ghist <= {ghist[0], upd_taken};
    end
  end
endmodule

module tourney_bpred_chk #(
  parameter int NC_N = 4, parameter int CR_N = 4, parameter int SEL_N = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pred_taken,
  input logic                  pred_use_corr,
  input logic                  upd_valid,
  input logic                  upd_taken,
  input logic                  nc_ok,
  input logic                  cr_ok,
  input logic [1:0]            ghist,
  input logic [NC_N-1:0][1:0]  nc_q,
  input logic [CR_N-1:0][1:0]  cr_q,
  input logic [SEL_N-1:0][1:0] sel_q
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!pred_taken && !pred_use_corr && ghist == 2'b00));

  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist == {$past(ghist[0]), $past(upd_taken)});

  assert_idle_hist_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  assert_idle_tables_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(nc_q) && $stable(cr_q) && $stable(sel_q)));

  assert_chooser_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && nc_ok == cr_ok) |=> $stable(sel_q));
endmodule

bind tourney_bpred tourney_bpred_chk #(.NC_N(NC_N), .CR_N(CR_N), .SEL_N(SEL_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .pred_taken(pred_taken), .pred_use_corr(pred_use_corr),
  .upd_valid(upd_valid), .upd_taken(upd_taken), .nc_ok(nc_ok), .cr_ok(cr_ok),
  .ghist(ghist), .nc_q(nc_q), .cr_q(cr_q), .sel_q(sel_q)
);

// File: tb/tourney_bpred_tb_top.sv
`timescale 1ns/1ps
module tourney_bpred_tb_top;
  localparam int PC_W = 32, PC_LSB = 2, NC_IDX = 10, CR_IDX = 8, SEL_IDX = 10;
  localparam int NC_N = 1 << NC_IDX, CR_N = 1 << (CR_IDX + 2), SEL_N = 1 << SEL_IDX;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic upd_valid = 0, upd_taken = 0;
  logic pred_taken, pred_use_corr;

  always #10 clk = ~clk;

  tourney_bpred dut_i (.clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_use_corr(pred_use_corr), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  logic [1:0] m_nc [NC_N];
  logic [1:0] m_cr [CR_N];
  logic [1:0] m_sel[SEL_N];
  logic [1:0] m_h;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];
  event mon_ev;

  function automatic logic [1:0] mstep(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic int inc(input logic [PC_W-1:0] pc); return int'(pc[PC_LSB+NC_IDX-1:PC_LSB]); endfunction
  function automatic int isel(input logic [PC_W-1:0] pc); return int'(pc[PC_LSB+SEL_IDX-1:PC_LSB]); endfunction
  function automatic int icr(input logic [PC_W-1:0] pc);
    return int'({pc[PC_LSB+CR_IDX-1:PC_LSB], m_h});
  endfunction

  task automatic model_reset();
    foreach (m_nc[i]) m_nc[i] = 2'b01;
    foreach (m_cr[i]) m_cr[i] = 2'b01;
    foreach (m_sel[i]) m_sel[i] = 2'b01;
    m_h = 2'b00;
  endtask

  // driver: present one outcome for one cycle, advance the model
  task automatic update(input logic [PC_W-1:0] pc, input logic t);
    logic nok, cok;
    @(negedge clk);
    upd_valid = 1; upd_pc = pc; upd_taken = t;
    nok = m_nc[inc(pc)][1] == t;
    cok = m_cr[icr(pc)][1] == t;
    @(negedge clk);
    upd_valid = 0;
    m_nc[inc(pc)] = mstep(m_nc[inc(pc)], t);
    m_cr[icr(pc)] = mstep(m_cr[icr(pc)], t);
    if (nok != cok) m_sel[isel(pc)] = mstep(m_sel[isel(pc)], cok);
    m_h = {m_h[0], t};
  endtask

  // driver: ask for a prediction and queue what the requirements give
  task automatic probe(input logic [PC_W-1:0] pc, input string tag);
    logic u, d;
    @(negedge clk);
    pred_pc = pc;
    u = m_sel[isel(pc)][1];
    d = u ? m_cr[icr(pc)][1] : m_nc[inc(pc)][1];
    exp_q.push_back({d, u});
    tag_q.push_back(tag);
    -> mon_ev;
    #5;
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // monitor: pop expected items and compare once outputs have settled
  always begin
    @(mon_ev);
    #2;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      check_bit({tg, " dir"}, pred_taken, e[1]);
      check_bit({tg, " src"}, pred_use_corr, e[0]);
    end
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  localparam logic [PC_W-1:0] PA = 32'h0000_0040;
  localparam logic [PC_W-1:0] PB = 32'h0000_0884;
  localparam logic [PC_W-1:0] ALIAS = 32'h0040_0000;

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state seen at several addresses
    probe(PA, "R1 reset"); probe(PB, "R1 reset"); probe(32'hFFFF_FFFC, "R1 reset");
    // R2 R5: one taken keeps 01->10 upper bit set; second saturates toward 11
    update(PA, 1); probe(PA, "R2 threshold");
    update(PA, 1); probe(PA, "R5 train");
    repeat (4) update(PA, 1);
    probe(PA, "R5 saturate high");
    // R5: walk down from 11, one step per outcome
    update(PA, 0); probe(PA, "R2 after one down");
    update(PA, 0); probe(PA, "R2 crossing");
    repeat (5) update(PA, 0);
    probe(PA, "R5 saturate low");
    // R8: changing update data with valid low has no effect
    @(negedge clk); upd_pc = PA; upd_taken = 1;
    @(negedge clk); upd_pc = PB; upd_taken = 1;
    @(negedge clk); upd_taken = 0;
    probe(PA, "R8 idle"); probe(PB, "R8 idle");
    // R3 R4 R6: alternating pattern moves the chooser onto the correlator
    for (int i = 0; i < 24; i++) begin
      update(PB, i[0]);
      probe(PB, "R6 alternate");
    end
    check_bit("R3 chooser on correlator", pred_use_corr, 1'b1);
    // R4: chooser saturation then agreement keeps it
    for (int i = 0; i < 12; i++) update(PB, i[0]);
    probe(PB, "R4 saturate");
    // R7: aliased addresses share entries
    probe(PB | ALIAS, "R7 alias");
    probe(PA | ALIAS, "R7 alias");
    // R4 R5 R6: mixed traffic over a few addresses
    for (int i = 0; i < 400; i++) begin
      logic [PC_W-1:0] pc;
      pc = {20'h0, 2'($urandom % 4), 8'($urandom % 6), 2'b00};
      update(pc, 1'($urandom % 3 != 0));
      probe(pc, "R4 mixed");
      probe(PB, "R6 mixed");
    end
    // R1: reset again mid-run
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); @(negedge clk); rst_n = 1;
    probe(PB, "R1 re-reset"); probe(PA, "R1 re-reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule